// File: doc/BRIEF.md
# Global Timer Comparator with Periodic Reload

This block watches a 64-bit free-running count supplied from outside and raises an event when the count reaches a programmed 64-bit target. Software programs the target as two 32-bit words. In one-shot use it writes the current count plus a delay. In periodic use it also writes a 32-bit step and turns on automatic reload. After each hit the target then moves forward by the step, so the events stay evenly spaced and never drift.

A hit latches an event flag. Software clears the flag by writing a one to it. An interrupt line, gated by an enable bit, follows the flag as a level. Each write to a target word, the step or the control word also sets its own sticky completion flag. Software polls these flags and clears them by writing ones. Register reads are registered and return data one cycle after the address is presented.

Top module: `gtimer_cmp`

## Requirements
- R1: After synchronous reset every register reads zero and `irq_o` is low.
- R2: The target low word at 0x200, the target high word at 0x204 and the step at 0x208 read back the last value written, one cycle after `rd_addr_i` is applied.
- R3: The control word at 0x240 holds the comparator enable in bit 0 and automatic reload in bit 1. Its other bits read as zero.
- R4: While the comparator is enabled, a cycle in which `cnt_i` equals the 64-bit target sets bit 0 of the event register at 0x244 at that clock edge. While disabled, equality sets nothing.
- R5: Writing 1 to bit 0 of 0x244 clears the event flag. Writing 0 leaves it unchanged.
- R6: If a match and a clearing write to 0x244 fall in the same cycle, the flag stays set.
- R7: With automatic reload on, the target becomes target + step at the same edge the flag sets, wrapping modulo 2^64. With reload off, a match leaves the target unchanged.
- R8: If software writes a target word in the same cycle as a reload, the written word takes the bus value. The reload for that match is dropped, and the other word keeps its value.
- R9: `irq_o` equals the event flag ANDed with bit 0 of the interrupt enable at 0x248, updated at the same edge as the flag. Clearing the enable lowers `irq_o` but leaves the flag set.
- R10: Completion flags at 0x24C set at the edge of the corresponding write: bit 0 for the target low word, bit 1 for the target high word, bit 2 for the step and bit 16 for the control word. They stay set until a one is written to that bit. Writes to 0x244 and 0x248 set no flag.
- R11: Writing 0 to both control bits stops the comparator. A later equality neither sets the flag nor moves the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Free-running count being watched |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Read byte address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can hit the same clock edge. One is a match with a software clear of the event flag. The other is a match with automatic reload together with a software write to the target. The bench holds `cnt_i` equal to the target so that matches repeat every cycle, and then issues the clearing write. The flag is judged still set. In a second test the bench drives equality and a target low-word write in the same cycle. The read-back target must hold the written low word and the unchanged high word, and must not hold the sum with the step.

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;
  localparam int OFS_CMP     = 'h200;
  localparam int OFS_STEP    = 'h208;
  localparam int OFS_CTRL    = 'h240;
  localparam int OFS_EVT     = 'h244;
  localparam int OFS_IEN     = 'h248;
  localparam int OFS_WDONE   = 'h24C;
  localparam int WDONE_CTRL  = 16;
endpackage

// File: rtl/gcmp_match.sv
module gcmp_match #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [DATA_W-1:0] step_i,
  input  logic              en_i,
  input  logic              auto_i,
  output logic              match_o,
  output logic              reload_req_o,
  output logic [CNT_W-1:0]  reload_val_o
);
  localparam int NW = CNT_W / DATA_W;

  logic [NW-1:0] eq_w;

  // per-word equality slices, reduced below
  for (genvar g = 0; g < NW; g++) begin : g_eq
    assign eq_w[g] = (cnt_i[g*DATA_W +: DATA_W] == cmp_i[g*DATA_W +: DATA_W]);
  end

  assign match_o      = en_i && (&eq_w);
  assign reload_req_o = match_o && auto_i;
  assign reload_val_o = cmp_i + {{(CNT_W-DATA_W){1'b0}}, step_i};
endmodule

// File: rtl/gcmp_regs.sv
module gcmp_regs
  import gcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              match_i,
  input  logic              reload_req_i,
  input  logic [CNT_W-1:0]  reload_val_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [DATA_W-1:0] step_o,
  output logic              en_o,
  output logic              auto_o,
  output logic              evt_o,
  output logic              ien_o,
  output logic [CNT_W/DATA_W+1:0] wdone_o,
  output logic              irq_o
);
  localparam int NW = CNT_W / DATA_W;
  localparam int NF = NW + 2;

  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [DATA_W-1:0] step_q;
  logic              en_q, auto_q, evt_q, evt_d, ien_q, ien_d, irq_q;
  logic [NF-1:0]     wdone_q, wdone_set, wdone_clr;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic [NW-1:0]     cmp_wr;
  logic              step_wr, ctrl_wr, evt_wr, ien_wr, wdone_wr;

  for (genvar g = 0; g < NW; g++) begin : g_wdec
    assign cmp_wr[g] = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CMP + 4*g));
  end
  assign step_wr  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_STEP));
  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CTRL));
  assign evt_wr   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_EVT));
  assign ien_wr   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_IEN));
  assign wdone_wr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_WDONE));

  // software write beats reload; reload is dropped in that cycle
  always_comb begin
    cmp_d = cmp_q;
    if (|cmp_wr) begin
      for (int i = 0; i < NW; i++)
        if (cmp_wr[i]) cmp_d[i*DATA_W +: DATA_W] = wr_data_i;
    end else if (reload_req_i) begin
      cmp_d = reload_val_i;
    end
  end

  assign evt_d = (evt_q & ~(evt_wr & wr_data_i[0])) | match_i;
  assign ien_d = ien_wr ? wr_data_i[0] : ien_q;

  always_comb begin
    wdone_set = {ctrl_wr, step_wr, cmp_wr};
    wdone_clr = '0;
    for (int i = 0; i <= NW; i++) wdone_clr[i] = wdone_wr & wr_data_i[i];
    wdone_clr[NW+1] = wdone_wr & wr_data_i[WDONE_CTRL];
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NW; i++)
      if (rd_addr_i == ADDR_W'(OFS_CMP + 4*i)) rd_d = cmp_q[i*DATA_W +: DATA_W];
    if (rd_addr_i == ADDR_W'(OFS_STEP)) rd_d = step_q;
    if (rd_addr_i == ADDR_W'(OFS_CTRL)) rd_d[1:0] = {auto_q, en_q};
    if (rd_addr_i == ADDR_W'(OFS_EVT))  rd_d[0] = evt_q;
    if (rd_addr_i == ADDR_W'(OFS_IEN))  rd_d[0] = ien_q;
    if (rd_addr_i == ADDR_W'(OFS_WDONE)) begin
      for (int i = 0; i <= NW; i++) rd_d[i] = wdone_q[i];
      rd_d[WDONE_CTRL] = wdone_q[NW+1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_q   <= '0;
      step_q  <= '0;
      en_q    <= 1'b0;
      auto_q  <= 1'b0;
      evt_q   <= 1'b0;
      ien_q   <= 1'b0;
      irq_q   <= 1'b0;
      wdone_q <= '0;
      rd_q    <= '0;
    end else begin
      cmp_q   <= cmp_d;
      if (step_wr) step_q <= wr_data_i;
      if (ctrl_wr) begin
        en_q   <= wr_data_i[0];
        auto_q <= wr_data_i[1];
      end
      evt_q   <= evt_d;
      ien_q   <= ien_d;
      irq_q   <= evt_d & ien_d;
      wdone_q <= (wdone_q & ~wdone_clr) | wdone_set;
      rd_q    <= rd_d;
    end
  end

  assign cmp_o     = cmp_q;
  assign step_o    = step_q;
  assign en_o      = en_q;
  assign auto_o    = auto_q;
  assign evt_o     = evt_q;
  assign ien_o     = ien_q;
  assign wdone_o   = wdone_q;
  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int NW = CNT_W / DATA_W;

  logic [CNT_W-1:0]  cmp_q, reload_val;
  logic [DATA_W-1:0] step_q;
  logic              en_q, auto_q, evt_q, ien_q, match, reload_req;
  logic [NW+1:0]     wdone_q;

  gcmp_match #(.DATA_W(DATA_W), .CNT_W(CNT_W)) match_i (
    .cnt_i        (cnt_i),
    .cmp_i        (cmp_q),
    .step_i       (step_q),
    .en_i         (en_q),
    .auto_i       (auto_q),
    .match_o      (match),
    .reload_req_o (reload_req),
    .reload_val_o (reload_val)
  );

  gcmp_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .match_i      (match),
    .reload_req_i (reload_req),
    .reload_val_i (reload_val),
    .cmp_o        (cmp_q),
    .step_o       (step_q),
    .en_o         (en_q),
    .auto_o       (auto_q),
    .evt_o        (evt_q),
    .ien_o        (ien_q),
    .wdone_o      (wdone_q),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/gtimer_cmp_chk.sv
module gtimer_cmp_chk
  import gcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [DATA_W-1:0] step_q,
  input logic              en_q,
  input logic              auto_q,
  input logic              evt_q,
  input logic              ien_q,
  input logic              irq_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CNT_W/DATA_W+1:0] wdone_q
);
  localparam int NW = CNT_W / DATA_W;

  logic             hit, cmp_write, evt_clear;
  logic [CNT_W-1:0] step_ext;

  assign hit       = en_q && (cnt_i == cmp_q);
  assign cmp_write = wr_en_i && ((wr_addr_i - ADDR_W'(OFS_CMP)) < ADDR_W'(4*NW));
  assign evt_clear = wr_en_i && (wr_addr_i == ADDR_W'(OFS_EVT)) && wr_data_i[0];
  assign step_ext  = CNT_W'(step_q);

  a_r4_match_sets: assert property (@(posedge clk_i) disable iff (rst_i)
    hit |=> evt_q);

  a_r7_reload_adds_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit && auto_q && !cmp_write) |=> (cmp_q == $past(cmp_q) + $past(step_ext)));

  a_r5_clear_works: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_clear && !hit) |=> !evt_q);

  a_r11_idle_no_event: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_q |=> !$rose(evt_q));

  a_r11_idle_target_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_q && !cmp_write) |=> $stable(cmp_q));

  a_r9_irq_level: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == (evt_q && ien_q));

  a_r10_low_word_done: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == ADDR_W'(OFS_CMP)) |=> wdone_q[0]);

  a_r10_ctrl_done: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == ADDR_W'(OFS_CTRL)) |=> wdone_q[NW+1]);
endmodule

bind gtimer_cmp gtimer_cmp_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cnt_i     (cnt_i),
  .cmp_q     (cmp_q),
  .step_q    (step_q),
  .en_q      (en_q),
  .auto_q    (auto_q),
  .evt_q     (evt_q),
  .ien_q     (ien_q),
  .irq_o     (irq_o),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .wdone_q   (wdone_q)
);

// File: tb/gtimer_cmp_tb_top.sv
module gtimer_cmp_tb_top;
  localparam int CLK_P = 10;

  localparam logic [11:0] A_LO = 12'h200, A_HI = 12'h204, A_STEP = 12'h208;
  localparam logic [11:0] A_CTRL = 12'h240, A_EVT = 12'h244, A_IEN = 12'h248, A_WD = 12'h24C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  gtimer_cmp dut_i (
    .clk_i(clk), .rst_i(rst), .cnt_i(cnt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic rdchk(string req, string what, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, {32'h0, v}, {32'h0, exp});
  endtask

  task automatic setcnt(logic [63:0] v);
    @(negedge clk);
    cnt = v;
  endtask

  task automatic t_reset();
    chk("R1", "irq after reset", {63'h0, irq}, 64'h0);
    rdchk("R1", "low word", A_LO, 32'h0);
    rdchk("R1", "high word", A_HI, 32'h0);
    rdchk("R1", "step", A_STEP, 32'h0);
    rdchk("R1", "control", A_CTRL, 32'h0);
    rdchk("R1", "event", A_EVT, 32'h0);
    rdchk("R1", "enable", A_IEN, 32'h0);
    rdchk("R1", "done flags", A_WD, 32'h0);
  endtask

  task automatic t_regs();
    wr(A_LO, 32'h1234_5678);
    wr(A_HI, 32'h9ABC_DEF0);
    wr(A_STEP, 32'h0000_0040);
    wr(A_CTRL, 32'hFFFF_FFFC);
    rdchk("R2", "low word", A_LO, 32'h1234_5678);
    rdchk("R2", "high word", A_HI, 32'h9ABC_DEF0);
    rdchk("R2", "step", A_STEP, 32'h0000_0040);
    rdchk("R3", "control spare bits", A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0000_0002);
    rdchk("R3", "control auto bit", A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
    wr(A_IEN, 32'h1);
    wr(A_EVT, 32'h1);
    rdchk("R10", "all done flags", A_WD, 32'h0001_0007);
    wr(A_WD, 32'h0001_0005);
    rdchk("R10", "partial clear", A_WD, 32'h0000_0002);
    wr(A_WD, 32'hFFFF_FFFF);
    rdchk("R10", "full clear", A_WD, 32'h0);
    wr(A_IEN, 32'h0);
  endtask

  task automatic t_match();
    wr(A_IEN, 32'h1);
    wr(A_LO, 32'h10);
    wr(A_HI, 32'h5);
    wr(A_CTRL, 32'h1);
    chk("R9", "irq idle", {63'h0, irq}, 64'h0);
    rdchk("R4", "no event before match", A_EVT, 32'h0);
    setcnt(64'h5_0000_0010);
    @(posedge clk);
    #1 chk("R9", "irq at match edge", {63'h0, irq}, 64'h1);
    setcnt(64'h0);
    rdchk("R4", "event after match", A_EVT, 32'h1);
    rdchk("R7", "one-shot target kept", A_LO, 32'h10);
    wr(A_IEN, 32'h0);
    chk("R9", "irq masked", {63'h0, irq}, 64'h0);
    rdchk("R9", "event kept while masked", A_EVT, 32'h1);
    wr(A_EVT, 32'h0);
    rdchk("R5", "zero write ignored", A_EVT, 32'h1);
    wr(A_EVT, 32'h1);
    rdchk("R5", "one clears", A_EVT, 32'h0);
    wr(A_CTRL, 32'h0);
    setcnt(64'h5_0000_0010);
    setcnt(64'h0);
    rdchk("R4", "disabled no event", A_EVT, 32'h0);
  endtask

  task automatic t_autoinc();
    wr(A_STEP, 32'h20);
    wr(A_LO, 32'hFFFF_FFF0);
    wr(A_HI, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h3);
    setcnt(64'hFFFF_FFFF_FFFF_FFF0);
    rdchk("R7", "wrapped low", A_LO, 32'h10);
    rdchk("R7", "wrapped high", A_HI, 32'h0);
    setcnt(64'h10);
    setcnt(64'h0);
    rdchk("R7", "second period low", A_LO, 32'h30);
    rdchk("R7", "second period high", A_HI, 32'h0);
    rdchk("R7", "event set", A_EVT, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_EVT, 32'h1);
  endtask

  task automatic t_setwins();
    wr(A_LO, 32'h77);
    wr(A_HI, 32'h0);
    wr(A_CTRL, 32'h1);
    setcnt(64'h77);
    wr(A_EVT, 32'h1);
    rdchk("R6", "match beats clear", A_EVT, 32'h1);
    setcnt(64'h0);
    wr(A_EVT, 32'h1);
    rdchk("R6", "clear after collision", A_EVT, 32'h0);
  endtask

  task automatic t_wr_reload();
    wr(A_CTRL, 32'h0);
    wr(A_STEP, 32'h100);
    wr(A_LO, 32'h500);
    wr(A_HI, 32'h0);
    wr(A_CTRL, 32'h3);
    @(negedge clk);
    cnt = 64'h500;
    wr_en = 1'b1; wr_addr = A_LO; wr_data = 32'h900;
    @(negedge clk);
    wr_en = 1'b0;
    cnt = 64'h0;
    rdchk("R8", "written low wins", A_LO, 32'h900);
    rdchk("R8", "high unchanged", A_HI, 32'h0);
    rdchk("R8", "event still set", A_EVT, 32'h1);
  endtask

  task automatic t_stop();
    wr(A_CTRL, 32'h0);
    wr(A_EVT, 32'h1);
    wr(A_IEN, 32'h1);
    setcnt(64'h900);
    setcnt(64'h0);
    rdchk("R11", "no event when stopped", A_EVT, 32'h0);
    rdchk("R11", "target frozen", A_LO, 32'h900);
    chk("R11", "irq quiet", {63'h0, irq}, 64'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_match();
    t_autoinc();
    t_setwins();
    t_wr_reload();
    t_stop();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule